// File: doc/BRIEF.md
# Periodic Down-Counting Timer

This block is a periodic timer with a down-counter, default width 32 bits. Software controls it through a small register port that completes each access in one cycle. The port carries an address, a write strobe with write data, and a read strobe with registered read data. While counting is switched on, the counter drops by one on every clock. When it reaches zero it raises a sticky event flag and restarts from a stored reload value. A single level interrupt line reports the flag whenever the interrupt is allowed.

There are four registers: control, live count, reload and status. Software may overwrite the live count at any time. A write to the reload register stores the new value and also restarts the count from it at once. The event flag stays set until software writes one to its bit. If a new event arrives in the same cycle as that clear, the event wins.

Top module: `cdown_timer`

## Requirements
- R1: After reset, all four registers read as zero, `irq` is 0 and `bus_rdata` is 0.
- R2: The control register is at offset 0x00. Bit 0 is the count-enable bit and bit 3 is the interrupt-enable bit. All other bits read as zero, whatever was written to them.
- R3: The live count is at offset 0x04 and can be read and written. While count-enable is 1, a nonzero count with no write to it drops by exactly one per clock.
- R4: A write to the reload register at offset 0x08 stores the value. On the next cycle the count equals the written value. This write takes priority over a decrement, a zero-reload and a same-cycle count write.
- R5: While count-enable is 1 and the count is zero, the event flag is set. On the next cycle the count equals the stored reload value; it does not wrap to all ones.
- R6: While count-enable is 0, the count holds its value. Writes to the count and reload registers still take effect.
- R7: The status register is at offset 0x0C, and bit 0 is the event flag. Writing 1 to bit 0 clears the flag, and writing 0 leaves it unchanged. Bits 31:1 read as zero.
- R8: If a zero event and a write-one-to-clear of the flag occur in the same cycle, the flag is 1 afterwards.
- R9: `irq` is 1 exactly when the event flag is 1 and interrupt-enable is 1.
- R10: With a reload value of 0 and count-enable 1, the flag is set on every cycle and the count stays at 0.
- R11: Read data appears on `bus_rdata` on the cycle after the read strobe and shows the register contents from before that clock edge. `bus_rdata` is 0 on any cycle that follows a cycle with no read strobe.
- R12: Any other address reads as zero, including unaligned offsets and offsets above 0x0C. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | W | Registered read data |
| irq | output | 1 | Level interrupt: event flag gated by interrupt-enable |

## Verification
The bound checker checks the following on every cycle:
- a one-step decrement while counting, and a steady hold while stopped;
- the reload on a zero event, and the precedence of a reload-register write;
- that a zero event always leaves the flag set;
- the interrupt gating;
- the idle value of the read bus.

Only the bench's scenarios show the following:
- the register layout and reserved-bit masking;
- write-one-to-clear against write-zero;
- the set-over-clear race landing on the exact zero cycle;
- the constant-zero reload;
- that unmapped writes leave every register untouched.

Random traffic is compared against a cycle model built from the requirements.

// File: rtl/cdown_timer_pkg.sv
package cdown_timer_pkg;

  // Register byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_COUNT  = 'h04;
  localparam int OFS_RELOAD = 'h08;
  localparam int OFS_STAT   = 'h0C;

  // Control bit positions
  localparam int BIT_RUN = 0;
  localparam int BIT_IE  = 3;

  typedef struct packed {
    logic ctrl;
    logic count;
    logic reload;
    logic stat;
  } reg_sel_t;

endpackage

// File: rtl/cdown_decode.sv
module cdown_decode
  import cdown_timer_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_t          sel
);

  always_comb begin
    sel = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):   sel.ctrl   = 1'b1;
      ADDR_W'(OFS_COUNT):  sel.count  = 1'b1;
      ADDR_W'(OFS_RELOAD): sel.reload = 1'b1;
      ADDR_W'(OFS_STAT):   sel.stat   = 1'b1;
      default:             sel        = '0;
    endcase
  end

endmodule

// File: rtl/cdown_counter.sv
module cdown_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_wr,
  input  logic         rel_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reload_q,
  output logic         zero_hit
);

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  assign zero_hit = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else begin
      if (rel_wr) reload_q <= wdata;
      // Priority: reload write, count write, zero reload, decrement
      if (rel_wr)        cnt_q <= wdata;
      else if (cnt_wr)   cnt_q <= wdata;
      else if (zero_hit) cnt_q <= reload_q;
      else if (run)      cnt_q <= step_down(cnt_q);
    end
  end

endmodule

// File: rtl/cdown_status.sv
module cdown_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic ie,
  output logic flag_q,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;   // set beats clear
    else if (clr_req) flag_q <= 1'b0;
  end

  assign irq = flag_q & ie;

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdown_timer_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  output logic              irq
);

  reg_sel_t       sel;
  logic           ctl_wr, cnt_wr, rel_wr, stat_clr;
  logic           run_q, ie_q;
  logic [W-1:0]   cnt_q, reload_q;
  logic           zero_hit, flag_q;
  logic [W-1:0]   rd_word;

  cdown_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .sel      (sel)
  );

  assign ctl_wr   = bus_wr & sel.ctrl;
  assign cnt_wr   = bus_wr & sel.count;
  assign rel_wr   = bus_wr & sel.reload;
  assign stat_clr = bus_wr & sel.stat & bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (ctl_wr) begin
      run_q <= bus_wdata[BIT_RUN];
      ie_q  <= bus_wdata[BIT_IE];
    end
  end

  cdown_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .cnt_wr   (cnt_wr),
    .rel_wr   (rel_wr),
    .wdata    (bus_wdata),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .zero_hit (zero_hit)
  );

  cdown_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (zero_hit),
    .clr_req (stat_clr),
    .ie      (ie_q),
    .flag_q  (flag_q),
    .irq     (irq)
  );

  always_comb begin
    rd_word = '0;
    unique case (1'b1)
      sel.ctrl: begin
        rd_word[BIT_RUN] = run_q;
        rd_word[BIT_IE]  = ie_q;
      end
      sel.count:  rd_word = cnt_q;
      sel.reload: rd_word = reload_q;
      sel.stat:   rd_word[0] = flag_q;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_rd,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic         irq,
  input logic         run_q,
  input logic         ie_q,
  input logic         cnt_wr,
  input logic         rel_wr,
  input logic         zero_hit,
  input logic         flag_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] reload_q
);

  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !cnt_wr && !rel_wr) |=> (cnt_q == $past(cnt_q) - W'(1)));

  p_reload_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_wr |=> (cnt_q == $past(bus_wdata) && reload_q == $past(bus_wdata)));

  p_zero_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && !cnt_wr && !rel_wr) |=> (cnt_q == $past(reload_q)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr && !rel_wr) |=> $stable(cnt_q));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> flag_q);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && ie_q));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind cdown_timer cdown_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .run_q     (run_q),
  .ie_q      (ie_q),
  .cnt_wr    (cnt_wr),
  .rel_wr    (rel_wr),
  .zero_hit  (zero_hit),
  .flag_q    (flag_q),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q)
);

// File: tb/cdown_timer_test.sv
`timescale 1ns/1ps
module cdown_timer_test;

  localparam int W = 32;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [W-1:0]      bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [W-1:0]      bus_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic         m_run = 0, m_ie = 0, m_flag = 0;
  logic [W-1:0] m_cnt = '0, m_rel = '0;

  always #4 clk = ~clk;   // 125 MHz

  cdown_timer #(.W(W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [W-1:0] ref_read(input logic [ADDR_W-1:0] a);
    case (a)
      6'h00: return {28'd0, m_ie, 2'b00, m_run};
      6'h04: return m_cnt;
      6'h08: return m_rel;
      6'h0C: return {31'd0, m_flag};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle, with the reference updated from pre-edge state
  task automatic step(input string tag, input logic [ADDR_W-1:0] a, input logic wr,
                      input logic [W-1:0] wd, input logic rd);
    logic [W-1:0] exp_rd, n_cnt;
    logic hit;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_wdata = wd; bus_rd = rd;
    exp_rd = rd ? ref_read(a) : '0;
    hit = m_run && (m_cnt == '0);
    n_cnt = m_cnt;
    if (wr && a == 6'h08)      n_cnt = wd;
    else if (wr && a == 6'h04) n_cnt = wd;
    else if (hit)              n_cnt = m_rel;
    else if (m_run)            n_cnt = m_cnt - 1;
    if (wr && a == 6'h08) m_rel = wd;
    if (wr && a == 6'h00) begin m_run = wd[0]; m_ie = wd[3]; end
    if (hit) m_flag = 1'b1;
    else if (wr && a == 6'h0C && wd[0]) m_flag = 1'b0;
    m_cnt = n_cnt;
    @(posedge clk);
    #2;
    check(tag, "rdata", bus_rdata, exp_rd);
    check("R9", "irq", {31'd0, irq}, {31'd0, m_flag & m_ie});
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a);
    step(tag, a, 1'b0, '0, 1'b1);
  endtask

  task automatic wr(input string tag, input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    step(tag, a, 1'b1, d, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] addrs [6];
    addrs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h06};
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1", "rdata after reset", bus_rdata, '0);
    check("R1", "irq after reset", {31'd0, irq}, '0);
    rd_chk("R1", 6'h00); rd_chk("R1", 6'h04); rd_chk("R1", 6'h08); rd_chk("R1", 6'h0C);

    // R2: reserved bits masked
    wr("R2", 6'h00, 32'hFFFF_FFF6); rd_chk("R2", 6'h00);
    wr("R2", 6'h00, 32'h0000_0008); rd_chk("R2", 6'h00);
    wr("R2", 6'h00, 32'h0);

    // R6: hold while stopped, writes still land
    wr("R6", 6'h04, 32'd100);
    step("R11", 6'h00, 1'b0, '0, 1'b0);
    step("R11", 6'h00, 1'b0, '0, 1'b0);
    rd_chk("R6", 6'h04);
    wr("R6", 6'h08, 32'd50); rd_chk("R6", 6'h04); rd_chk("R6", 6'h08);

    // R3: decrement while running
    wr("R3", 6'h04, 32'd20);
    wr("R3", 6'h00, 32'h9);
    repeat (4) rd_chk("R3", 6'h04);

    // R4: reload write restarts immediately
    wr("R4", 6'h08, 32'd6); rd_chk("R4", 6'h04); rd_chk("R4", 6'h08);

    // R5 / R8: race a clear against the zero event
    while (m_cnt != 0) rd_chk("R5", 6'h04);
    wr("R8", 6'h0C, 32'h1);
    rd_chk("R8", 6'h0C);
    rd_chk("R5", 6'h04);

    // R7: write-zero no effect, write-one clears
    wr("R7", 6'h00, 32'h8);
    wr("R7", 6'h0C, 32'hFFFF_FFFE); rd_chk("R7", 6'h0C);
    wr("R7", 6'h0C, 32'h1); rd_chk("R7", 6'h0C);

    // R10: zero reload
    wr("R10", 6'h08, 32'd0);
    wr("R10", 6'h00, 32'h9);
    wr("R10", 6'h0C, 32'h1);
    rd_chk("R10", 6'h0C); rd_chk("R10", 6'h04); rd_chk("R10", 6'h04);

    // R12: unmapped offsets
    wr("R12", 6'h00, 32'h0);
    wr("R12", 6'h0C, 32'h1);
    wr("R12", 6'h10, 32'hFFFF_FFFF);
    wr("R12", 6'h05, 32'hFFFF_FFFF);
    wr("R12", 6'h3C, 32'hFFFF_FFFF);
    rd_chk("R12", 6'h10); rd_chk("R12", 6'h05);
    rd_chk("R12", 6'h00); rd_chk("R12", 6'h04); rd_chk("R12", 6'h08); rd_chk("R12", 6'h0C);

    // Random traffic: small reloads so zero events happen
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic w;
      logic [W-1:0] d;
      a = addrs[$urandom_range(0, 5)];
      w = ($urandom_range(0, 9) < 3);
      d = ($urandom_range(0, 3) == 0) ? $urandom() : W'($urandom_range(0, 12));
      step("R3", a, w, d, $urandom_range(0, 1) == 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule